// File: doc/BRIEF.md
# Command ring queue controller

This block drains a ring of fixed-size commands that software builds in memory for an interrupt translation unit. Software programs a 64-bit ring descriptor with the page-aligned base address of the ring and its length in 4 KiB pages. It then sets a global enable and advances a producer offset to announce new work. The block keeps a consumer offset. While the unit is enabled and the two offsets differ, it reads the 32-byte command at the consumer offset over a request/response memory port. It offers that command downstream on a valid/ready handshake, and after acceptance it advances the consumer offset by one slot, wrapping at the end of the ring.

Software can advance the producer offset again while a drain is running. The running drain picks up the new target and keeps going until it catches up. If a memory read reports an error, the block abandons the unread commands by pulling the producer offset back onto the consumer offset. While the unit is enabled the descriptor is frozen, and rewriting it while disabled restarts consumption from the ring start.

Top module: `cmdq_ctrl`

## Requirements
- R1: After reset the unit is disabled, the descriptor and both offsets read 0, the control word reads 0x8000_0000, and neither `mem_req_o` nor `cmd_valid_o` is asserted.
- R2: The control word at byte address 0x00 always returns 1 in bit 31, and bit 0 holds the enable. Only a write whose address is exactly 0x00 changes the enable, taken from write-data bit 0. Writes to 0x01–0x03 leave it unchanged.
- R3: The descriptor is split into two 32-bit halves: bits 31:0 at 0x08 and bits 63:32 at 0x0C. A write to one half leaves the other half unchanged. The ring length is (bits 7:0 + 1) × 4096 bytes, and the ring base address is descriptor bits 47:12 with 12 zero bits below them.
- R4: A descriptor write while enabled has no effect. An accepted descriptor write sets the consumer offset to 0.
- R5: The producer offset is at 0x10 and the consumer offset at 0x18. Each holds only bits 19:5. Its bits 4:0 and 31:20 read as 0, and write-data bits outside 19:5 are dropped. The upper halves at 0x14 and 0x1C read as 0.
- R6: A producer-offset write whose masked value is greater than the ring length leaves the offset unchanged. A value equal to the ring length is accepted.
- R7: Writes to the consumer offset at 0x18 or 0x1C have no effect.
- R8: The memory read address is the ring base plus the consumer offset. `mem_req_o` stays high with a stable address until `mem_rsp_valid_i`. At most one read is outstanding, and no read is issued while a command is waiting downstream.
- R9: A successful response is presented on `cmd_data_o` with `cmd_valid_o`. Both stay stable until `cmd_ready_i`.
- R10: Each accepted command advances the consumer offset by 32, and the offset wraps to 0 when it reaches the ring length. Fetching stops when the consumer offset equals the producer offset.
- R11: A producer-offset write made while a read is in flight only moves the target, and the running drain continues through all the new slots.
- R12: An error response presents no command, leaves the consumer offset unchanged, sets the producer offset equal to it, and stops fetching.
- R13: A new read starts only while enabled. Clearing the enable lets a pending command complete but starts no further read. Enabling again resumes from the consumer offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | RADDR_W | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i`, combinational |
| mem_req_o | output | 1 | Memory read request, held until response |
| mem_addr_o | output | PA_W | Byte address of the command to read |
| mem_rsp_valid_i | input | 1 | Memory response strobe |
| mem_rsp_err_i | input | 1 | Memory response carries an error |
| mem_rsp_data_i | input | CMD_W | 32-byte command read from memory |
| cmd_valid_o | output | 1 | Command available downstream |
| cmd_ready_i | input | 1 | Downstream accepts the command |
| cmd_data_o | output | CMD_W | Command contents |

## Verification
On every cycle the assertions check several properties. The descriptor never changes while enabled, and a memory read never overlaps a pending command. A request and an offered command stay stable until their handshake. The consumer offset stays inside the ring and moves only on acceptance or a write. An error response rolls the producer offset back, and a read starts only when enabled with work pending. The bench scenarios show what needs a known history: the exact sequence of read addresses, including the wrap at the ring end. They also show that extending the target mid-drain fetches every new slot, and that resumption after an error or a disable starts from the right slot. The ignored writes (wrong control byte, locked descriptor, oversize producer offset, consumer offset) are shown by reading back state and counting fetches.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  localparam int CMD_BYTES  = 32;
  localparam int CMD_SHIFT  = 5;
  localparam int PAGE_SHIFT = 12;
  localparam int PAGES_W    = 8;
  localparam int OFFS_W     = 20;
  localparam int IDX_W      = OFFS_W - CMD_SHIFT;
  localparam int RING_W     = OFFS_W + 1;
  localparam int REG_DW     = 32;
  localparam int DESC_W     = 64;

  typedef enum logic [2:0] {
    REG_CTRL    = 3'd0,
    REG_RSVD    = 3'd1,
    REG_DESC_LO = 3'd2,
    REG_DESC_HI = 3'd3,
    REG_PROD_LO = 3'd4,
    REG_PROD_HI = 3'd5,
    REG_CONS_LO = 3'd6,
    REG_CONS_HI = 3'd7
  } reg_sel_e;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_MEM  = 2'd1,
    FS_HOLD = 2'd2
  } fetch_state_e;

  function automatic logic [REG_DW-1:0] idx_to_word(input logic [IDX_W-1:0] idx);
    return {{(REG_DW-OFFS_W){1'b0}}, idx, {CMD_SHIFT{1'b0}}};
  endfunction
endpackage

// File: rtl/cmdq_regfile.sv
module cmdq_regfile
  import cmdq_pkg::*;
#(
  parameter int RADDR_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic [RADDR_W-1:0]   addr_i,
  input  logic [REG_DW-1:0]    wdata_i,
  input  logic [IDX_W-1:0]     prod_idx_i,
  input  logic [IDX_W-1:0]     cons_idx_i,
  output logic [REG_DW-1:0]    rdata_o,
  output logic                 en_o,
  output logic [DESC_W-1:0]    desc_o,
  output logic                 prod_wr_o,
  output logic                 clr_cons_o
);
  logic     in_win;
  reg_sel_e sel;
  logic     ctrl_wr, desc_lo_wr, desc_hi_wr;
  logic     en_q;
  logic [DESC_W-1:0] desc_q;

  assign in_win = ((addr_i >> 5) == '0);
  assign sel    = reg_sel_e'(addr_i[4:2]);

  assign ctrl_wr    = wr_i && (addr_i == '0);
  assign desc_lo_wr = wr_i && in_win && (sel == REG_DESC_LO) && !en_q;
  assign desc_hi_wr = wr_i && in_win && (sel == REG_DESC_HI) && !en_q;
  assign prod_wr_o  = wr_i && in_win && (sel == REG_PROD_LO);
  assign clr_cons_o = desc_lo_wr || desc_hi_wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      desc_q <= '0;
    end else begin
      if (ctrl_wr)    en_q                 <= wdata_i[0];
      if (desc_lo_wr) desc_q[REG_DW-1:0]   <= wdata_i;
      if (desc_hi_wr) desc_q[DESC_W-1:REG_DW] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (in_win) begin
      unique case (sel)
        REG_CTRL:    rdata_o = {1'b1, {(REG_DW-2){1'b0}}, en_q};
        REG_DESC_LO: rdata_o = desc_q[REG_DW-1:0];
        REG_DESC_HI: rdata_o = desc_q[DESC_W-1:REG_DW];
        REG_PROD_LO: rdata_o = idx_to_word(prod_idx_i);
        REG_CONS_LO: rdata_o = idx_to_word(cons_idx_i);
        default:     rdata_o = '0;
      endcase
    end
  end

  assign en_o   = en_q;
  assign desc_o = desc_q;
endmodule

// File: rtl/cmdq_ptrs.sv
module cmdq_ptrs
  import cmdq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [RING_W-1:0] ring_bytes_i,
  input  logic              sw_wr_i,
  input  logic [IDX_W-1:0]  sw_idx_i,
  input  logic              clr_cons_i,
  input  logic              adv_i,
  input  logic              err_i,
  output logic [IDX_W-1:0]  prod_idx_o,
  output logic [IDX_W-1:0]  cons_idx_o
);
  logic [IDX_W-1:0]  prod_q, cons_q, cons_nxt;
  logic [RING_W-1:0] cand_bytes, inc_bytes;
  logic              cand_ok, at_end;

  assign cand_bytes = {1'b0, sw_idx_i, {CMD_SHIFT{1'b0}}};
  assign cand_ok    = (cand_bytes <= ring_bytes_i);

  assign inc_bytes  = {1'b0, cons_q, {CMD_SHIFT{1'b0}}} + RING_W'(CMD_BYTES);
  assign at_end     = (inc_bytes >= ring_bytes_i);
  assign cons_nxt   = at_end ? '0 : cons_q + IDX_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_q <= '0;
      cons_q <= '0;
    end else begin
      // fetch error rollback wins over a same-cycle software update
      if (err_i)                   prod_q <= cons_q;
      else if (sw_wr_i && cand_ok) prod_q <= sw_idx_i;
      if (clr_cons_i)  cons_q <= '0;
      else if (adv_i)  cons_q <= cons_nxt;
    end
  end

  assign prod_idx_o = prod_q;
  assign cons_idx_o = cons_q;
endmodule

// File: rtl/cmdq_fetch.sv
module cmdq_fetch
  import cmdq_pkg::*;
#(
  parameter int CMD_W = 256,
  parameter int PA_W  = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [IDX_W-1:0] prod_idx_i,
  input  logic [IDX_W-1:0] cons_idx_i,
  input  logic [PA_W-1:0]  ring_base_i,
  output logic             mem_req_o,
  output logic [PA_W-1:0]  mem_addr_o,
  input  logic             mem_rsp_valid_i,
  input  logic             mem_rsp_err_i,
  input  logic [CMD_W-1:0] mem_rsp_data_i,
  output logic             cmd_valid_o,
  input  logic             cmd_ready_i,
  output logic [CMD_W-1:0] cmd_data_o,
  output logic             adv_o,
  output logic             err_o
);
  fetch_state_e     state_q;
  logic [PA_W-1:0]  addr_q;
  logic [CMD_W-1:0] data_q;
  logic             pending;

  assign pending = en_i && (cons_idx_i != prod_idx_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FS_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      unique case (state_q)
        FS_IDLE: if (pending) begin
          addr_q  <= ring_base_i + PA_W'({cons_idx_i, {CMD_SHIFT{1'b0}}});
          state_q <= FS_MEM;
        end
        FS_MEM: if (mem_rsp_valid_i) begin
          if (mem_rsp_err_i) state_q <= FS_IDLE;
          else begin
            data_q  <= mem_rsp_data_i;
            state_q <= FS_HOLD;
          end
        end
        FS_HOLD: if (cmd_ready_i) state_q <= FS_IDLE;
        default: state_q <= FS_IDLE;
      endcase
    end
  end

  assign mem_req_o   = (state_q == FS_MEM);
  assign mem_addr_o  = addr_q;
  assign cmd_valid_o = (state_q == FS_HOLD);
  assign cmd_data_o  = data_q;
  assign adv_o       = (state_q == FS_HOLD) && cmd_ready_i;
  assign err_o       = (state_q == FS_MEM) && mem_rsp_valid_i && mem_rsp_err_i;
endmodule

// File: rtl/cmdq_ctrl.sv
module cmdq_ctrl
  import cmdq_pkg::*;
#(
  parameter int RADDR_W = 8,
  parameter int CMD_W   = 256,
  parameter int PA_W    = 48
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_wr_i,
  input  logic [RADDR_W-1:0] reg_addr_i,
  input  logic [REG_DW-1:0]  reg_wdata_i,
  output logic [REG_DW-1:0]  reg_rdata_o,
  output logic               mem_req_o,
  output logic [PA_W-1:0]    mem_addr_o,
  input  logic               mem_rsp_valid_i,
  input  logic               mem_rsp_err_i,
  input  logic [CMD_W-1:0]   mem_rsp_data_i,
  output logic               cmd_valid_o,
  input  logic               cmd_ready_i,
  output logic [CMD_W-1:0]   cmd_data_o
);
  logic              en;
  logic [DESC_W-1:0] desc_q;
  logic [IDX_W-1:0]  prod_idx, cons_idx;
  logic [RING_W-1:0] ring_bytes;
  logic [PA_W-1:0]   ring_base;
  logic              prod_wr, clr_cons, adv, fetch_err;

  assign ring_bytes = (RING_W'(desc_q[PAGES_W-1:0]) + RING_W'(1)) << PAGE_SHIFT;
  assign ring_base  = {desc_q[PA_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};

  cmdq_regfile #(.RADDR_W(RADDR_W)) i_regfile (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (reg_wr_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .prod_idx_i (prod_idx),
    .cons_idx_i (cons_idx),
    .rdata_o    (reg_rdata_o),
    .en_o       (en),
    .desc_o     (desc_q),
    .prod_wr_o  (prod_wr),
    .clr_cons_o (clr_cons)
  );

  cmdq_ptrs i_ptrs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ring_bytes_i (ring_bytes),
    .sw_wr_i      (prod_wr),
    .sw_idx_i     (reg_wdata_i[OFFS_W-1:CMD_SHIFT]),
    .clr_cons_i   (clr_cons),
    .adv_i        (adv),
    .err_i        (fetch_err),
    .prod_idx_o   (prod_idx),
    .cons_idx_o   (cons_idx)
  );

  cmdq_fetch #(.CMD_W(CMD_W), .PA_W(PA_W)) i_fetch (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .en_i            (en),
    .prod_idx_i      (prod_idx),
    .cons_idx_i      (cons_idx),
    .ring_base_i     (ring_base),
    .mem_req_o       (mem_req_o),
    .mem_addr_o      (mem_addr_o),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .mem_rsp_err_i   (mem_rsp_err_i),
    .mem_rsp_data_i  (mem_rsp_data_i),
    .cmd_valid_o     (cmd_valid_o),
    .cmd_ready_i     (cmd_ready_i),
    .cmd_data_o      (cmd_data_o),
    .adv_o           (adv),
    .err_o           (fetch_err)
  );
endmodule

// File: rtl/cmdq_ctrl_chk.sv
module cmdq_ctrl_chk
  import cmdq_pkg::*;
#(
  parameter int RADDR_W = 8,
  parameter int CMD_W   = 256,
  parameter int PA_W    = 48
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               reg_wr_i,
  input logic [RADDR_W-1:0] reg_addr_i,
  input logic [REG_DW-1:0]  reg_rdata_o,
  input logic               mem_req_o,
  input logic [PA_W-1:0]    mem_addr_o,
  input logic               mem_rsp_valid_i,
  input logic               mem_rsp_err_i,
  input logic               cmd_valid_o,
  input logic               cmd_ready_i,
  input logic [CMD_W-1:0]   cmd_data_o,
  input logic               en_i,
  input logic [DESC_W-1:0]  desc_i,
  input logic [IDX_W-1:0]   prod_idx_i,
  input logic [IDX_W-1:0]   cons_idx_i,
  input logic [RING_W-1:0]  ring_bytes_i
);
  assert_ctrl_word_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == '0) |-> (reg_rdata_o[31] && (reg_rdata_o[0] == en_i)));

  assert_desc_locked_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> $stable(desc_i));

  assert_cons_moves_only_on_event_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(cmd_valid_o && cmd_ready_i) && !reg_wr_i) |=> $stable(cons_idx_i));

  assert_one_outstanding_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_req_o && cmd_valid_o));

  assert_req_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rsp_valid_i) |=> (mem_req_o && $stable(mem_addr_o)));

  assert_cmd_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !cmd_ready_i) |=> (cmd_valid_o && $stable(cmd_data_o)));

  assert_cons_in_ring_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, cons_idx_i, {CMD_SHIFT{1'b0}}} < ring_bytes_i));

  assert_err_rollback_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_rsp_valid_i && mem_rsp_err_i) |=>
      ((prod_idx_i == cons_idx_i) && !cmd_valid_o));

  assert_start_needs_work_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) |-> ($past(en_i) && $past(cons_idx_i != prod_idx_i)));
endmodule

bind cmdq_ctrl cmdq_ctrl_chk #(.RADDR_W(RADDR_W), .CMD_W(CMD_W), .PA_W(PA_W)) i_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .reg_wr_i        (reg_wr_i),
  .reg_addr_i      (reg_addr_i),
  .reg_rdata_o     (reg_rdata_o),
  .mem_req_o       (mem_req_o),
  .mem_addr_o      (mem_addr_o),
  .mem_rsp_valid_i (mem_rsp_valid_i),
  .mem_rsp_err_i   (mem_rsp_err_i),
  .cmd_valid_o     (cmd_valid_o),
  .cmd_ready_i     (cmd_ready_i),
  .cmd_data_o      (cmd_data_o),
  .en_i            (en),
  .desc_i          (desc_q),
  .prod_idx_i      (prod_idx),
  .cons_idx_i      (cons_idx),
  .ring_bytes_i    (ring_bytes)
);

// File: tb/test_cmdq_ctrl.sv
`timescale 1ns/1ps
module test_cmdq_ctrl;
  localparam logic [47:0] BASE1 = 48'h12_0000_5000;
  localparam logic [47:0] BASE2 = 48'h12_0000_9000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_wr = 1'b0;
  logic [7:0]   reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic         mem_req;
  logic [47:0]  mem_addr;
  logic         rsp_valid, rsp_err;
  logic [255:0] rsp_data;
  logic         cmd_valid;
  logic         cmd_ready;
  logic [255:0] cmd_data;

  int n_chk = 0;
  int n_fail = 0;
  int mem_lat = 1;
  int ready_gap = 0;
  bit ready_block = 0;
  bit err_arm = 0;
  logic [47:0] err_addr = '0;
  logic [47:0] req_log [0:255];
  logic [255:0] acc_log [0:255];
  int n_req = 0;
  int n_acc = 0;
  bit overlap_seen = 0;

  always #10 clk = ~clk;

  cmdq_ctrl i_cmdq_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rsp_valid_i(rsp_valid), .mem_rsp_err_i(rsp_err), .mem_rsp_data_i(rsp_data),
    .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready), .cmd_data_o(cmd_data)
  );

  function automatic logic [255:0] pat(input logic [47:0] a);
    logic [255:0] v;
    for (int w = 0; w < 8; w++) v[w*32 +: 32] = a[31:0] ^ (32'(w + 1) * 32'h1010_0101);
    return v;
  endfunction

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
    end
  endtask

  // memory model
  initial begin
    int wait_cnt;
    wait_cnt = 0;
    rsp_valid = 1'b0; rsp_err = 1'b0; rsp_data = '0;
    forever begin
      @(negedge clk);
      if (mem_req && cmd_valid) overlap_seen = 1;
      if (rsp_valid) begin
        rsp_valid = 1'b0; rsp_err = 1'b0; wait_cnt = 0;
      end else if (mem_req) begin
        wait_cnt++;
        if (wait_cnt >= mem_lat) begin
          rsp_valid = 1'b1;
          rsp_err   = err_arm && (mem_addr == err_addr);
          rsp_data  = pat(mem_addr);
          if (n_req < 256) req_log[n_req] = mem_addr;
          n_req++;
          wait_cnt = 0;
        end
      end
    end
  end

  // consumer model
  initial begin
    int gap_cnt;
    gap_cnt = 0;
    cmd_ready = 1'b0;
    forever begin
      @(negedge clk);
      if (ready_block) cmd_ready = 1'b0;
      else if (ready_gap == 0) cmd_ready = 1'b1;
      else if (gap_cnt >= ready_gap) begin cmd_ready = 1'b1; gap_cnt = 0; end
      else begin cmd_ready = 1'b0; gap_cnt++; end
      if (cmd_ready && cmd_valid) begin
        if (n_acc < 256) acc_log[n_acc] = cmd_data;
        n_acc++;
      end
    end
  end

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic clear_logs();
    n_req = 0; n_acc = 0; overlap_seen = 0;
  endtask

  task automatic drain(input string what);
    logic [31:0] r, w;
    bit ok;
    ok = 0;
    for (int i = 0; i < 4000; i++) begin
      reg_read(8'h18, r);
      reg_read(8'h10, w);
      if (r == w && !mem_req && !cmd_valid) begin ok = 1; break; end
    end
    chk({what, " drain"}, 64'(ok), 64'd1);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    reg_read(8'h00, d); chk("R1 ctrl", d, 32'h8000_0000);
    reg_read(8'h08, d); chk("R1 desc lo", d, 0);
    reg_read(8'h10, d); chk("R1 prod", d, 0);
    reg_read(8'h18, d); chk("R1 cons", d, 0);
    chk("R1 mem_req", 64'(mem_req), 0);
    chk("R1 cmd_valid", 64'(cmd_valid), 0);
  endtask

  task automatic t_ctrl();
    logic [31:0] d;
    reg_write(8'h01, 32'h1);
    reg_read(8'h00, d); chk("R2 write at byte 1 ignored", d, 32'h8000_0000);
    reg_write(8'h00, 32'hFFFF_FFFF);
    reg_read(8'h00, d); chk("R2 enable set", d, 32'h8000_0001);
    reg_write(8'h00, 32'h0);
    reg_read(8'h00, d); chk("R2 enable clear", d, 32'h8000_0000);
  endtask

  task automatic t_desc();
    logic [31:0] d;
    reg_write(8'h08, 32'h0000_5001);
    reg_write(8'h0C, 32'h0000_0012);
    reg_read(8'h08, d); chk("R3 desc lo", d, 32'h0000_5001);
    reg_read(8'h0C, d); chk("R3 desc hi", d, 32'h0000_0012);
    reg_write(8'h0C, 32'hABCD_0012);
    reg_read(8'h08, d); chk("R3 lo preserved", d, 32'h0000_5001);
    reg_read(8'h0C, d); chk("R3 hi updated", d, 32'hABCD_0012);
  endtask

  task automatic t_ptr();
    logic [31:0] d;
    reg_write(8'h10, 32'h0000_003F);
    reg_read(8'h10, d); chk("R5 low bits dropped", d, 32'h20);
    reg_write(8'h10, 32'hFFF0_2000);
    reg_read(8'h10, d); chk("R6 equal to ring length accepted, R5 high bits dropped", d, 32'h2000);
    reg_write(8'h10, 32'h0000_2020);
    reg_read(8'h10, d); chk("R6 oversize ignored", d, 32'h2000);
    reg_read(8'h14, d); chk("R5 prod upper half", d, 0);
    reg_write(8'h18, 32'h40);
    reg_write(8'h1C, 32'hFFFF);
    reg_read(8'h18, d); chk("R7 cons write ignored", d, 0);
    reg_read(8'h1C, d); chk("R7 cons upper half", d, 0);
    reg_write(8'h10, 32'h0);
    reg_read(8'h10, d); chk("R5 prod cleared", d, 0);
  endtask

  task automatic t_fetch();
    logic [31:0] d;
    clear_logs(); mem_lat = 1; ready_gap = 0;
    reg_write(8'h00, 32'h1);
    reg_write(8'h10, 32'h60);
    drain("R10 basic");
    chk("R8 request count", 64'(n_req), 3);
    chk("R9 accept count", 64'(n_acc), 3);
    for (int i = 0; i < 3; i++) begin
      chk("R8 read address", 64'(req_log[i]), 64'(BASE1 + 48'(i * 32)));
      chk("R9 command data", 64'(acc_log[i][63:0]), 64'(pat(BASE1 + 48'(i * 32)) >> 0));
    end
    reg_read(8'h18, d); chk("R10 cons after drain", d, 32'h60);
    repeat (5) @(negedge clk);
    chk("R10 stopped", 64'(mem_req), 0);
  endtask

  task automatic t_backpressure();
    clear_logs(); mem_lat = 2; ready_gap = 2;
    reg_write(8'h10, 32'hC0);
    drain("R9 backpressure");
    chk("R9 accept count", 64'(n_acc), 3);
    chk("R8 request count", 64'(n_req), 3);
    for (int i = 0; i < 3; i++)
      chk("R9 data in order", 64'(acc_log[i][255:192]), 64'(pat(BASE1 + 48'h60 + 48'(i * 32)) >> 192));
    chk("R8 no read while command pending", 64'(overlap_seen), 0);
    ready_gap = 0;
  endtask

  task automatic t_extend();
    logic [31:0] d;
    clear_logs(); mem_lat = 3;
    reg_write(8'h10, 32'hE0);
    repeat (2) @(negedge clk);
    chk("R11 read in flight", 64'(mem_req), 1);
    reg_write(8'h10, 32'h140);
    drain("R11 extend");
    chk("R11 accept count", 64'(n_acc), 4);
    chk("R11 request count", 64'(n_req), 4);
    chk("R11 last address", 64'(req_log[3]), 64'(BASE1 + 48'h120));
    reg_read(8'h18, d); chk("R11 cons", d, 32'h140);
    mem_lat = 1;
  endtask

  task automatic t_error();
    logic [31:0] d;
    clear_logs();
    err_addr = BASE1 + 48'h180; err_arm = 1;
    reg_write(8'h10, 32'h1C0);
    drain("R12 error");
    reg_read(8'h10, d); chk("R12 prod rolled back", d, 32'h180);
    reg_read(8'h18, d); chk("R12 cons unchanged at error", d, 32'h180);
    chk("R12 accepted before error", 64'(n_acc), 2);
    chk("R12 reads incl. failing one", 64'(n_req), 3);
    repeat (6) @(negedge clk);
    chk("R12 halted", 64'(n_req), 3);
    err_arm = 0;
    reg_write(8'h10, 32'h1A0);
    drain("R12 resume");
    chk("R12 resume count", 64'(n_acc), 3);
    chk("R12 resume slot", 64'(acc_log[2][31:0]), 64'(pat(BASE1 + 48'h180) >> 0) & 64'hFFFF_FFFF);
  endtask

  task automatic t_lock();
    logic [31:0] d;
    reg_write(8'h08, 32'h0000_9000);
    reg_read(8'h08, d); chk("R4 locked while enabled", d, 32'h0000_5001);
    reg_read(8'h18, d); chk("R4 cons kept on locked write", d, 32'h1A0);
    reg_write(8'h00, 32'h0);
    reg_write(8'h08, 32'h0000_9000);
    reg_read(8'h08, d); chk("R4 accepted when disabled", d, 32'h0000_9000);
    reg_read(8'h18, d); chk("R4 cons cleared", d, 0);
  endtask

  task automatic t_wrap();
    logic [31:0] d;
    clear_logs();
    repeat (10) @(negedge clk);
    chk("R13 no read while disabled", 64'(n_req), 0);
    reg_write(8'h10, 32'hFC0);
    reg_write(8'h00, 32'h1);
    drain("R10 fill");
    chk("R10 fill count", 64'(n_acc), 126);
    clear_logs();
    reg_write(8'h10, 32'h20);
    drain("R10 wrap");
    chk("R10 wrap count", 64'(n_req), 3);
    chk("R10 slot before end", 64'(req_log[0]), 64'(BASE2 + 48'hFC0));
    chk("R10 last slot", 64'(req_log[1]), 64'(BASE2 + 48'hFE0));
    chk("R10 wrapped slot", 64'(req_log[2]), 64'(BASE2));
    reg_read(8'h18, d); chk("R10 cons after wrap", d, 32'h20);
  endtask

  task automatic t_disable();
    logic [31:0] d;
    clear_logs(); ready_block = 1;
    reg_write(8'h10, 32'h80);
    for (int i = 0; i < 50 && !cmd_valid; i++) @(negedge clk);
    chk("R13 command pending", 64'(cmd_valid), 1);
    reg_write(8'h00, 32'h0);
    ready_block = 0;
    repeat (20) @(negedge clk);
    chk("R13 pending command completed", 64'(n_acc), 1);
    chk("R13 no new read", 64'(n_req), 1);
    reg_read(8'h18, d); chk("R13 cons after disable", d, 32'h40);
    reg_write(8'h00, 32'h1);
    drain("R13 resume");
    chk("R13 resume count", 64'(n_acc), 3);
    chk("R13 resume slot", 64'(req_log[1]), 64'(BASE2 + 48'h40));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_ctrl();
    t_desc();
    t_ptr();
    t_fetch();
    t_backpressure();
    t_extend();
    t_error();
    t_lock();
    t_wrap();
    t_disable();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule